// File: doc/BRIEF.md
# Spindle Motor Speed Regulator

This block picks one of two speed settings for a disk spindle motor. It does this by counting how many ticks of a 50 kHz timing strobe fall between index marks. After a start, the motor is forced to high speed for a fixed number of index marks so that airflow can purge the pack. After that the block drops to normal speed and enters a regulation phase.

In the regulation phase it counts ticks between successive marks. When a revolution runs longer than the tick limit, the block selects high speed again. It holds high speed until an interval ends at or under the limit. A ready flag reports that the purge is over and the most recent complete revolution was fast enough. A stop input returns everything to the purge state, ready for the next start.

Top module: `spindle_speed_reg`

## Requirements
- R1: After reset, fast_o is 1 and ready_o is 0.
- R2: fast_o stays 1 through the first PURGE_MARKS (default 1024) index marks after reset or stop, whatever the tick counts are. It reads 0 from the cycle after the clock edge that samples the last of those marks.
- R3: An index mark is a 0-to-1 change of index_i between two clock edges. A level held high for many cycles counts as one mark.
- R4: In the regulation phase, once more than SLOW_LIMIT (default 2000) ticks have been counted since the last mark, fast_o goes to 1 and ready_o goes to 0. This happens in the cycle after the edge that samples tick number SLOW_LIMIT+1, without waiting for the next mark.
- R5: In the regulation phase, a mark that ends an interval of SLOW_LIMIT ticks or fewer sets fast_o to 0 in the following cycle. A mark that ends a longer interval leaves fast_o at 1. A tick sampled in the same cycle as a mark belongs to the new interval.
- R6: ready_o goes to 1 only in the cycle after a regulation-phase mark that ends an interval within the limit. ready_o is never 1 while fast_o is 1, and ready_o is 0 when the purge phase ends.
- R7: The tick count saturates at SLOW_LIMIT+1 and does not wrap. An interval of any length above the limit is judged too slow, including lengths past the counter's binary range.
- R8: While stop_i is 1, fast_o is 1, ready_o is 0, and marks are ignored. After stop_i is released, a full purge of PURGE_MARKS marks is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Holds the block in its cleared purge state |
| tick_i | input | 1 | One-cycle strobe of the 50 kHz timing reference |
| index_i | input | 1 | Index mark level from the drive, synchronous to clk_i |
| fast_o | output | 1 | 1 selects high spindle speed, 0 selects normal speed |
| ready_o | output | 1 | Purge complete and last revolution within limit |

## Verification
The two functions that can fall in the same cycle are closing an interval, when an index mark arrives, and counting a tick. The bench ends an interval of exactly SLOW_LIMIT ticks with a mark cycle that also carries a tick. It checks that the closed interval is judged good, so fast_o drops. It then checks that the shared tick was credited to the new interval: fast_o rises after only SLOW_LIMIT further ticks instead of SLOW_LIMIT+1.

// File: rtl/spindle_speed_pkg.sv
package spindle_speed_pkg;
  typedef enum logic {
    PH_PURGE    = 1'b0,
    PH_REGULATE = 1'b1
  } phase_e;

  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/spd_mark_detect.sv
module spd_mark_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic index_i,
  output logic mark_o
);
  logic index_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) index_q <= 1'b0;
    else         index_q <= index_i;
  end

  assign mark_o = index_i & ~index_q;
endmodule

// File: rtl/spd_interval_timer.sv
module spd_interval_timer #(
  parameter int unsigned SLOW_LIMIT = 2000,
  parameter int unsigned CNT_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             mark_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SLOW_LIMIT + 1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (mark_i) begin
      // a coincident tick opens the new interval
      count_q <= tick_i ? CNT_W'(1) : '0;
    end else if (tick_i && (count_q != SAT)) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/spd_purge_counter.sv
module spd_purge_counter #(
  parameter int unsigned PURGE_MARKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic mark_i,
  output logic done_o,
  output logic finish_o
);
  localparam int unsigned PW = spindle_speed_pkg::width_for(PURGE_MARKS);
  localparam logic [PW-1:0] LAST = PW'(PURGE_MARKS - 1);
  localparam logic [PW-1:0] FULL = PW'(PURGE_MARKS);

  logic [PW-1:0] cnt_q;

  assign done_o   = (cnt_q == FULL);
  assign finish_o = mark_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (mark_i && !done_o) cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/spd_speed_ctrl.sv
module spd_speed_ctrl #(
  parameter int unsigned SLOW_LIMIT = 2000,
  parameter int unsigned CNT_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             purge_done_i,
  input  logic             purge_finish_i,
  input  logic             mark_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             fast_o,
  output logic             ready_o
);
  import spindle_speed_pkg::*;

  localparam logic [CNT_W-1:0] LIM = CNT_W'(SLOW_LIMIT);

  phase_e phase;
  logic   good_mark, overrun;
  logic   fast_q, ready_q;

  assign phase     = purge_done_i ? PH_REGULATE : PH_PURGE;
  assign good_mark = mark_i && (count_i <= LIM);
  // this tick pushes the open interval past the limit
  assign overrun   = !mark_i && tick_i && (count_i == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q  <= 1'b1;
      ready_q <= 1'b0;
    end else if (clear_i) begin
      fast_q  <= 1'b1;
      ready_q <= 1'b0;
    end else if (phase == PH_PURGE) begin
      ready_q <= 1'b0;
      fast_q  <= !purge_finish_i;
    end else if (mark_i) begin
      fast_q  <= !good_mark;
      ready_q <= good_mark;
    end else if (overrun) begin
      fast_q  <= 1'b1;
      ready_q <= 1'b0;
    end
  end

  assign fast_o  = fast_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/spindle_speed_reg.sv
module spindle_speed_reg #(
  parameter int unsigned PURGE_MARKS = 1024,
  parameter int unsigned SLOW_LIMIT  = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic tick_i,
  input  logic index_i,
  output logic fast_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = spindle_speed_pkg::width_for(SLOW_LIMIT + 1);

  logic             mark_raw, mark;
  logic [CNT_W-1:0] count;
  logic             purge_done, purge_finish;

  spd_mark_detect i_mark (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .index_i (index_i),
    .mark_o  (mark_raw)
  );

  assign mark = mark_raw && !stop_i;

  spd_interval_timer #(.SLOW_LIMIT(SLOW_LIMIT), .CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (stop_i),
    .tick_i  (tick_i),
    .mark_i  (mark),
    .count_o (count)
  );

  spd_purge_counter #(.PURGE_MARKS(PURGE_MARKS)) i_purge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (stop_i),
    .mark_i   (mark),
    .done_o   (purge_done),
    .finish_o (purge_finish)
  );

  spd_speed_ctrl #(.SLOW_LIMIT(SLOW_LIMIT), .CNT_W(CNT_W)) i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (stop_i),
    .purge_done_i   (purge_done),
    .purge_finish_i (purge_finish),
    .mark_i         (mark),
    .tick_i         (tick_i),
    .count_i        (count),
    .fast_o         (fast_o),
    .ready_o        (ready_o)
  );
endmodule

// File: rtl/spindle_speed_chk.sv
module spindle_speed_chk #(
  parameter int unsigned SLOW_LIMIT = 2000,
  parameter int unsigned CNT_W      = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             stop_i,
  input logic             tick_i,
  input logic             mark,
  input logic [CNT_W-1:0] count,
  input logic             purge_done,
  input logic             fast_o,
  input logic             ready_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(SLOW_LIMIT);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SLOW_LIMIT + 1);

  p_purge_fast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !purge_done |-> fast_o);

  p_mark_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark |=> !mark);

  p_overrun_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_done && !stop_i && !mark && tick_i && (count == LIM) |=> fast_o && !ready_o);

  p_good_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_done && !stop_i && mark && (count <= LIM) |=> !fast_o && ready_o);

  p_ready_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !fast_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i && !mark && (count == SAT) |=> (count == SAT));

  p_stop_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> fast_o && !ready_o && !purge_done);
endmodule

bind spindle_speed_reg spindle_speed_chk #(.SLOW_LIMIT(SLOW_LIMIT), .CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .tick_i     (tick_i),
  .mark       (mark),
  .count      (count),
  .purge_done (purge_done),
  .fast_o     (fast_o),
  .ready_o    (ready_o)
);

// File: tb/test_spindle_speed_reg.sv
module test_spindle_speed_reg;
  localparam int CLK_PERIOD = 10;
  localparam int MARKS      = 1024;
  localparam int LIMIT      = 2000;

  typedef struct packed {
    int unsigned ticks;
    logic        fast;
    logic        ready;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{ticks: 1500, fast: 1'b0, ready: 1'b1},
    '{ticks: 2000, fast: 1'b0, ready: 1'b1},
    '{ticks: 2001, fast: 1'b1, ready: 1'b0},
    '{ticks: 1999, fast: 1'b0, ready: 1'b1},
    '{ticks: 2500, fast: 1'b1, ready: 1'b0},
    '{ticks: 2002, fast: 1'b1, ready: 1'b0},
    '{ticks: 100,  fast: 1'b0, ready: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_i = 1'b0;
  logic tick_i = 1'b0;
  logic index_i = 1'b0;
  logic fast_o, ready_o;
  int checks = 0;
  int failures = 0;
  logic prev_fast;

  always #(CLK_PERIOD/2) clk = ~clk;

  spindle_speed_reg i_spindle_speed_reg (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .stop_i  (stop_i),
    .tick_i  (tick_i),
    .index_i (index_i),
    .fast_o  (fast_o),
    .ready_o (ready_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_ticks(input int unsigned n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic mark();
    index_i = 1'b1;
    @(negedge clk);
    index_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic marks(input int n);
    for (int i = 0; i < n; i++) mark();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 fast after reset", fast_o, 1'b1);
    check("R1 ready after reset", ready_o, 1'b0);

    // R2: long intervals during purge are not judged
    run_ticks(2500);
    mark();
    check("R2 purge ignores slow interval", fast_o, 1'b1);
    marks(MARKS - 2);
    check("R2 fast before last purge mark", fast_o, 1'b1);
    mark();
    check("R2 normal after purge", fast_o, 1'b0);
    check("R6 ready low at purge end", ready_o, 1'b0);

    // table walk: R4 mid-interval, R5/R6 at marks
    prev_fast = 1'b0;
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].ticks > LIMIT) begin
        run_ticks(LIMIT);
        check("R4 at limit unchanged", fast_o, prev_fast);
        run_ticks(1);
        check("R4 overrun sets fast", fast_o, 1'b1);
        check("R4 overrun clears ready", ready_o, 1'b0);
        run_ticks(VECS[v].ticks - LIMIT - 1);
      end else begin
        run_ticks(VECS[v].ticks);
      end
      mark();
      check("R5 fast after mark", fast_o, VECS[v].fast);
      check("R6 ready after mark", ready_o, VECS[v].ready);
      prev_fast = VECS[v].fast;
    end

    // R5: tick coincident with mark goes to the new interval
    run_ticks(LIMIT);
    tick_i = 1'b1;
    index_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    index_i = 1'b0;
    @(negedge clk);
    check("R5 coincident mark judges 2000 good", fast_o, 1'b0);
    run_ticks(LIMIT - 1);
    check("R5 new interval holds coincident tick, at limit", fast_o, 1'b0);
    run_ticks(1);
    check("R5 new interval over after limit more ticks", fast_o, 1'b1);
    mark();
    run_ticks(10);
    mark();
    check("R5 recovered", fast_o, 1'b0);

    // R7: saturation past binary range of the counter
    run_ticks(3000);
    check("R7 fast during long gap", fast_o, 1'b1);
    mark();
    check("R7 saturated interval still slow", fast_o, 1'b1);
    check("R7 ready stays low", ready_o, 1'b0);
    run_ticks(500);
    mark();
    check("R7 good interval after saturation", ready_o, 1'b1);

    // R8: stop clears and ignores marks
    stop_i = 1'b1;
    @(negedge clk);
    check("R8 stop forces fast", fast_o, 1'b1);
    check("R8 stop clears ready", ready_o, 1'b0);
    marks(5);
    check("R8 marks ignored while stopped", fast_o, 1'b1);
    stop_i = 1'b0;
    @(negedge clk);
    // R3: a long high level is one mark
    index_i = 1'b1;
    repeat (20) @(negedge clk);
    index_i = 1'b0;
    @(negedge clk);
    marks(MARKS - 2);
    check("R3 R8 held level counted once, purge not done", fast_o, 1'b1);
    mark();
    check("R8 full purge required after stop", fast_o, 1'b0);
    run_ticks(100);
    mark();
    check("R6 ready after restart", ready_o, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule